// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block keeps the control state for the physical memory protection unit of one hart. It holds sixteen 8-bit configuration entries and sixteen address registers. Each entry carries a lock flag, a two-bit match mode and read, write and execute permissions. Configuration entries are reached through XLEN-wide words that each pack several entries. Address registers are reached one at a time. The stored fields are also driven out in decoded form for a separate matching unit, which is outside this block.

Writes to both register kinds take effect at the next clock edge. Reads are combinational from the stored state. A locked entry discards any new configuration byte and freezes its own address register. If an entry is locked and also uses top-of-range matching, it also freezes the address register of the entry below it, because that register is its lower bound. The bank is parameterised for a 32-bit or a 64-bit register width. In the 64-bit form only even configuration word indices exist, and stored addresses are cut to 54 bits.

Top module: `prot_csr_bank`

## Requirements
- R1: After reset every configuration entry and every address register reads zero, so every entry is unlocked and in mode OFF.
- R2: Entry bit layout: bit 7 is lock, bits 4:3 are the match mode (00 OFF, 01 TOR, 10 NA4, 11 NAPOT), bit 2 is execute, bit 1 is write and bit 0 is read. The decoded outputs show these fields for every entry.
- R3: With XLEN=32, configuration word n (0 to 3) holds entries 4n to 4n+3, and entry 4n+k sits in bits 8k+7:8k.
- R4: With XLEN=64, word index 0 holds entries 0 to 7 and index 2 holds entries 8 to 15, and entry j sits in byte j mod 8.
- R5: A stored configuration byte is the written byte ANDed with 0x9F, so bits 6:5 always read as zero.
- R6: Within one configuration write, each byte whose entry is already locked is discarded. The other bytes of the same write are still stored.
- R7: A write to address register i is ignored while entry i is locked.
- R8: A write to address register i is also ignored while entry i+1 is locked with mode TOR. Entry i+1 being locked with any other mode does not block the write.
- R9: With XLEN=64, a written address keeps bits 53:0 and stores zero above them. With XLEN=32 the whole word is stored.
- R10: All bytes of one configuration write are judged against the lock state from before that write. A write that sets a lock is stored, and the new value is readable on the cycle after the write.
- R11: With XLEN=64, an odd configuration index raises the illegal-access flag, reads as zero and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_idx_i | input | 2 | Configuration word index |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | XLEN | Configuration write word |
| cfg_rdata_o | output | XLEN | Configuration read word |
| cfg_bad_o | output | 1 | Index is not valid for this XLEN |
| addr_idx_i | input | 4 | Address register index |
| addr_we_i | input | 1 | Address write strobe |
| addr_wdata_i | input | XLEN | Address write word |
| addr_rdata_o | output | XLEN | Address read word |
| ent_lock_o | output | 16 | Lock flag per entry |
| ent_mode_o | output | 32 | Match mode per entry, two bits each |
| ent_x_o | output | 16 | Execute permission per entry |
| ent_w_o | output | 16 | Write permission per entry |
| ent_r_o | output | 16 | Read permission per entry |

## Verification
If a lock or mode bit is stored wrong, a later write that should be dropped is kept, or one that should be kept is dropped. This shows up on the read port one cycle after that write. The bench therefore writes each protected register first, locks it, writes again, and then reads it back. A fault in packing or masking changes the read word combinationally at once. Odd indices are also exercised on the 64-bit instance, to check that the flag rises and that no entry changes.

// File: rtl/prot_csr_pkg.sv
package prot_csr_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_TOR   = 2'b01,
        MODE_NA4   = 2'b10,
        MODE_NAPOT = 2'b11
    } prot_mode_e;

    localparam int ENT_BITS = 8;
    localparam int LOCK_BIT = 7;
    localparam logic [ENT_BITS-1:0] ENT_KEEP = 8'h9F;

endpackage

// File: rtl/prot_cfg_slot.sv
module prot_cfg_slot
    import prot_csr_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_i,
    input  logic [ENT_BITS-1:0] byte_i,
    output logic [ENT_BITS-1:0] cfg_o
);

    logic [ENT_BITS-1:0] cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (wr_i && !cfg_q[LOCK_BIT]) begin
            cfg_q <= byte_i & ENT_KEEP;
        end
    end

    assign cfg_o = cfg_q;

    // R6
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_q[LOCK_BIT] |=> $stable(cfg_q));

    // R5
    rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (cfg_q[6:5] == 2'b00));

endmodule

// File: rtl/prot_addr_slot.sv
module prot_addr_slot #(
    parameter int XLEN = 32,
    parameter int KEEP = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_i,
    input  logic            freeze_i,
    input  logic [XLEN-1:0] data_i,
    output logic [XLEN-1:0] addr_o
);

    localparam logic [XLEN-1:0] KEEP_MASK = {XLEN{1'b1}} >> (XLEN - KEEP);

    logic [XLEN-1:0] addr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q <= '0;
        end else if (wr_i && !freeze_i) begin
            addr_q <= data_i & KEEP_MASK;
        end
    end

    assign addr_o = addr_q;

    // R7 R8
    freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_i |=> $stable(addr_q));

    // R9
    upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ((addr_q & ~KEEP_MASK) == '0));

endmodule

// File: rtl/prot_csr_bank.sv
module prot_csr_bank
    import prot_csr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_ENT = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [1:0]                 cfg_idx_i,
    input  logic                       cfg_we_i,
    input  logic [XLEN-1:0]            cfg_wdata_i,
    output logic [XLEN-1:0]            cfg_rdata_o,
    output logic                       cfg_bad_o,
    input  logic [$clog2(NUM_ENT)-1:0] addr_idx_i,
    input  logic                       addr_we_i,
    input  logic [XLEN-1:0]            addr_wdata_i,
    output logic [XLEN-1:0]            addr_rdata_o,
    output logic [NUM_ENT-1:0]         ent_lock_o,
    output logic [2*NUM_ENT-1:0]       ent_mode_o,
    output logic [NUM_ENT-1:0]         ent_x_o,
    output logic [NUM_ENT-1:0]         ent_w_o,
    output logic [NUM_ENT-1:0]         ent_r_o
);

    localparam int PER_WORD  = XLEN / ENT_BITS;
    localparam int NUM_GRP   = NUM_ENT / PER_WORD;
    localparam int GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int STRIDE_LG = (XLEN == 64) ? 1 : 0;
    localparam int ADDR_KEEP = (XLEN == 64) ? 54 : XLEN;

    logic [ENT_BITS-1:0]      cfg_ent  [NUM_ENT];
    logic [XLEN-1:0]          cfg_word [NUM_GRP];
    logic [XLEN-1:0]          addr_reg [NUM_ENT];
    logic [NUM_ENT*ENT_BITS-1:0] cfg_flat;
    logic [GRP_W-1:0]         grp_sel;
    logic                     cfg_wr_ok;

    assign cfg_bad_o = (XLEN == 64) && cfg_idx_i[0];
    assign grp_sel   = GRP_W'(cfg_idx_i >> STRIDE_LG);
    assign cfg_wr_ok = cfg_we_i && !cfg_bad_o;

    for (genvar j = 0; j < NUM_ENT; j++) begin : g_ent
        localparam int GRP  = j / PER_WORD;
        localparam int LANE = j % PER_WORD;

        prot_cfg_slot u_cfg (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .wr_i   (cfg_wr_ok && (grp_sel == GRP_W'(GRP))),
            .byte_i (cfg_wdata_i[ENT_BITS*LANE +: ENT_BITS]),
            .cfg_o  (cfg_ent[j])
        );

        assign cfg_word[GRP][ENT_BITS*LANE +: ENT_BITS] = cfg_ent[j];
        assign cfg_flat[ENT_BITS*j +: ENT_BITS]         = cfg_ent[j];
        assign ent_lock_o[j]       = cfg_ent[j][LOCK_BIT];
        assign ent_mode_o[2*j +: 2] = cfg_ent[j][4:3];
        assign ent_x_o[j]          = cfg_ent[j][2];
        assign ent_w_o[j]          = cfg_ent[j][1];
        assign ent_r_o[j]          = cfg_ent[j][0];
    end

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_addr
        logic upper_tor;

        if (i == NUM_ENT - 1) begin : g_last
            assign upper_tor = 1'b0;
        end else begin : g_mid
            assign upper_tor = cfg_ent[i+1][LOCK_BIT] &&
                               (prot_mode_e'(cfg_ent[i+1][4:3]) == MODE_TOR);
        end

        prot_addr_slot #(
            .XLEN (XLEN),
            .KEEP (ADDR_KEEP)
        ) u_addr (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .wr_i     (addr_we_i && (addr_idx_i == i)),
            .freeze_i (cfg_ent[i][LOCK_BIT] || upper_tor),
            .data_i   (addr_wdata_i),
            .addr_o   (addr_reg[i])
        );
    end

    always_comb begin
        cfg_rdata_o = cfg_bad_o ? '0 : cfg_word[grp_sel];
    end

    assign addr_rdata_o = addr_reg[addr_idx_i];

    // R11
    bad_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_bad_o |-> (cfg_rdata_o == '0));

    // R11
    bad_write_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_bad_o) |=> $stable(cfg_flat));

    // R6
    lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ent_lock_o != '0) |=> ((ent_lock_o & $past(ent_lock_o)) == $past(ent_lock_o)));

endmodule

// File: tb/prot_csr_bank_tb_top.sv
module prot_csr_bank_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    logic [1:0]  c_idx = '0;
    logic        c_we  = 1'b0;
    logic [31:0] c_wd  = '0;
    logic [31:0] c_rd;
    logic        c_bad;
    logic [3:0]  a_idx = '0;
    logic        a_we  = 1'b0;
    logic [31:0] a_wd  = '0;
    logic [31:0] a_rd;
    logic [15:0] lk, xx, ww, rr;
    logic [31:0] md;

    logic [1:0]  d_idx = '0;
    logic        d_we  = 1'b0;
    logic [63:0] d_wd  = '0;
    logic [63:0] d_rd;
    logic        d_bad;
    logic [3:0]  e_idx = '0;
    logic        e_we  = 1'b0;
    logic [63:0] e_wd  = '0;
    logic [63:0] e_rd;
    logic [15:0] lk64, xx64, ww64, rr64;
    logic [31:0] md64;

    prot_csr_bank #(.XLEN(32)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_idx_i(c_idx), .cfg_we_i(c_we), .cfg_wdata_i(c_wd),
        .cfg_rdata_o(c_rd), .cfg_bad_o(c_bad),
        .addr_idx_i(a_idx), .addr_we_i(a_we), .addr_wdata_i(a_wd),
        .addr_rdata_o(a_rd),
        .ent_lock_o(lk), .ent_mode_o(md), .ent_x_o(xx), .ent_w_o(ww), .ent_r_o(rr)
    );

    prot_csr_bank #(.XLEN(64)) dut64_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_idx_i(d_idx), .cfg_we_i(d_we), .cfg_wdata_i(d_wd),
        .cfg_rdata_o(d_rd), .cfg_bad_o(d_bad),
        .addr_idx_i(e_idx), .addr_we_i(e_we), .addr_wdata_i(e_wd),
        .addr_rdata_o(e_rd),
        .ent_lock_o(lk64), .ent_mode_o(md64), .ent_x_o(xx64), .ent_w_o(ww64), .ent_r_o(rr64)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr32(input logic [1:0] idx, input logic [31:0] data);
        @(negedge clk);
        c_idx = idx; c_wd = data; c_we = 1'b1;
        @(negedge clk);
        c_we = 1'b0;
    endtask

    task automatic cfg_rd32(input logic [1:0] idx, output logic [31:0] val);
        c_idx = idx; #1; val = c_rd;
    endtask

    task automatic addr_wr32(input logic [3:0] idx, input logic [31:0] data);
        @(negedge clk);
        a_idx = idx; a_wd = data; a_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0;
    endtask

    task automatic addr_rd32(input logic [3:0] idx, output logic [31:0] val);
        a_idx = idx; #1; val = a_rd;
    endtask

    task automatic cfg_wr64(input logic [1:0] idx, input logic [63:0] data);
        @(negedge clk);
        d_idx = idx; d_wd = data; d_we = 1'b1;
        @(negedge clk);
        d_we = 1'b0;
    endtask

    task automatic cfg_rd64(input logic [1:0] idx, output logic [63:0] val);
        d_idx = idx; #1; val = d_rd;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            cfg_rd32(2'(k), v);
            chk("R1 cfg word zero", 64'(v), 64'h0);
        end
        addr_rd32(4'd0, v);
        chk("R1 addr zero", 64'(v), 64'h0);
        chk("R1 locks clear", 64'(lk), 64'h0);
        chk("R1 modes OFF", 64'(md), 64'h0);
    endtask

    task automatic t_pack32();
        logic [31:0] v;
        cfg_wr32(2'd1, 32'h1B0A_0907);
        cfg_rd32(2'd1, v);
        chk("R3 word1 readback", 64'(v), 64'h1B0A_0907);
        cfg_rd32(2'd0, v);
        chk("R3 word0 untouched", 64'(v), 64'h0);
        chk("R2 modes entries 7..4", 64'(md[15:8]), 64'hD4);
        chk("R2 execute entries 7..4", 64'(xx[7:4]), 64'h1);
        chk("R2 write entries 7..4", 64'(ww[7:4]), 64'hD);
        chk("R2 read entries 7..4", 64'(rr[7:4]), 64'hB);
    endtask

    task automatic t_mask_lock();
        logic [31:0] v;
        cfg_wr32(2'd3, 32'hFFE0_6060);
        cfg_rd32(2'd3, v);
        chk("R5 reserved bits masked", 64'(v), 64'h9F80_0000);
        chk("R10 locks visible next cycle", 64'(lk[15:12]), 64'hC);
        cfg_wr32(2'd3, 32'h0101_0101);
        cfg_rd32(2'd3, v);
        chk("R6 locked bytes kept, others stored", 64'(v), 64'h9F80_0101);
    endtask

    task automatic t_addr_lock();
        logic [31:0] v;
        addr_wr32(4'd8, 32'h0000_1234);
        addr_wr32(4'd9, 32'h0000_5678);
        addr_rd32(4'd8, v);
        chk("R7 addr8 before lock", 64'(v), 64'h1234);
        cfg_wr32(2'd2, 32'h0000_8901);
        cfg_rd32(2'd2, v);
        chk("R10 lock and neighbour in one write", 64'(v), 64'h0000_8901);
        chk("R2 entry9 mode TOR", 64'(md[19:18]), 64'h1);
        cfg_wr32(2'd2, 32'h0000_0000);
        cfg_rd32(2'd2, v);
        chk("R6 entry9 kept, entry8 cleared", 64'(v), 64'h0000_8900);
        addr_wr32(4'd8, 32'h0000_AAAA);
        addr_rd32(4'd8, v);
        chk("R8 addr8 frozen by locked TOR entry9", 64'(v), 64'h1234);
        addr_wr32(4'd9, 32'h0000_BBBB);
        addr_rd32(4'd9, v);
        chk("R7 addr9 frozen by own lock", 64'(v), 64'h5678);
        addr_wr32(4'd10, 32'h0000_CCCC);
        addr_rd32(4'd10, v);
        chk("R7 addr10 unlocked written", 64'(v), 64'hCCCC);
        addr_wr32(4'd13, 32'hDDDD_DDDD);
        addr_rd32(4'd13, v);
        chk("R8 addr13 written, entry14 locked OFF", 64'(v), 64'hDDDD_DDDD);
        addr_wr32(4'd14, 32'h0000_EEEE);
        addr_rd32(4'd14, v);
        chk("R7 addr14 frozen by own lock", 64'(v), 64'h0);
    endtask

    task automatic t_rv64();
        logic [63:0] v;
        cfg_wr64(2'd0, 64'h1B0A_0907_0504_0302);
        cfg_rd64(2'd0, v);
        chk("R4 rv64 index0 readback", v, 64'h1B0A_0907_0504_0302);
        chk("R4 rv64 entry7 mode", 64'(md64[15:14]), 64'h3);
        cfg_wr64(2'd2, 64'hFF00_0000_0000_0011);
        cfg_rd64(2'd2, v);
        chk("R4 rv64 index2 readback", v, 64'h9F00_0000_0000_0011);
        chk("R4 rv64 entry15 locked", 64'(lk64[15]), 64'h1);
        cfg_wr64(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        d_idx = 2'd1; #1;
        chk("R11 odd index flagged", 64'(d_bad), 64'h1);
        chk("R11 odd index reads zero", d_rd, 64'h0);
        cfg_rd64(2'd0, v);
        chk("R11 index0 unchanged", v, 64'h1B0A_0907_0504_0302);
        cfg_rd64(2'd2, v);
        chk("R11 index2 unchanged", v, 64'h9F00_0000_0000_0011);
        chk("R11 index2 not flagged", 64'(d_bad), 64'h0);
        @(negedge clk);
        e_idx = 4'd3; e_wd = 64'hFFFF_FFFF_FFFF_FFFF; e_we = 1'b1;
        @(negedge clk);
        e_we = 1'b0; #1;
        chk("R9 rv64 address truncated", e_rd, 64'h003F_FFFF_FFFF_FFFF);
    endtask

    task automatic t_addr32_full();
        logic [31:0] v;
        addr_wr32(4'd2, 32'hFFFF_FFFF);
        addr_rd32(4'd2, v);
        chk("R9 rv32 full word stored", 64'(v), 64'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack32();
        t_mask_lock();
        t_addr_lock();
        t_addr32_full();
        t_rv64();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule